// File: doc/BRIEF.md
# Control-Flow Integrity Enable Resolver

This block keeps the control-flow-integrity configuration of a hart: a shadow-stack enable and a landing-pad enable at each of the machine, supervisor and hypervisor configuration levels, plus one landing-pad enable that applies to machine mode itself. From these bits, the current privilege level, the virtualization flag and two build parameters (supervisor level present, hypervisor present), it produces two effective enables for the running mode. `xsse` turns shadow stacks on. `xlpe` turns landing-pad checks on.

The CSR port is a plain single-cycle strobe with no back-pressure. Reads return data in the same cycle as `csr_req`. Writes take effect at the next rising clock edge. When a higher-level shadow-stack enable is clear, the lower-level shadow-stack fields read as zero and writes to them are dropped. The block also flags illegal CSR accesses. These are addresses that do not exist in the configured build, and accesses to the shadow-stack pointer from a mode whose shadow stack is off. Finally, it reports whether the page-table permission code write-only (`xwr` = 010) is reserved for the stage being walked.

Top module: `cfi_gate_unit`

## Requirements
- R1: After reset every stored enable is 0, and a read of any implemented configuration CSR returns 0.
- R2: In the machine (0x30A), supervisor (0x10A) and hypervisor (0x60A) configuration CSRs, the shadow-stack enable is bit 3 and the landing-pad enable is bit 2. In the machine security CSR (0x747), the machine landing-pad enable is bit 10. All other bits read 0. A legal write is visible to a read from the next cycle on.
- R3: In machine mode (priv 3), `xsse` is 1 and `xlpe` equals the machine landing-pad enable.
- R4: With the supervisor level present, S-mode (priv 1, V=0) takes both enables from the machine configuration CSR. VS-mode (priv 1, V=1) takes them from the hypervisor configuration CSR, where the shadow-stack bit is effective only while the machine shadow-stack bit is 1.
- R5: With the supervisor level present, U-mode (priv 0, V=0) takes both enables from the supervisor configuration CSR. In VU-mode (priv 0, V=1), `xsse` additionally requires the effective hypervisor shadow-stack bit.
- R6: Without a supervisor level, U-mode takes both enables from the machine configuration CSR, and priv 1 yields 0 for both.
- R7: While the machine shadow-stack bit is 0, the supervisor and hypervisor shadow-stack fields read 0 and writes to them leave them unchanged.
- R8: While V=1 and the hypervisor shadow-stack bit is 0, the supervisor shadow-stack field reads 0 and writes to it leave it unchanged.
- R9: An access to the shadow-stack pointer CSR (0x011) below machine mode while `xsse` is 0 raises `csr_illegal`. In machine mode it is always legal.
- R10: `pte_rsv` is 1 exactly when `pte_xwr` is 010 and the effective shadow-stack bit of the selected stage is 0. That bit is the machine one for the single stage and the hypervisor one for the guest stage.
- R11: An address not implemented in the build raises `csr_illegal`, reads 0 and changes no state. The supervisor and hypervisor CSRs are absent without a supervisor level, and the hypervisor CSR is absent without a hypervisor.
- R12: `xsse` and `xlpe` follow a change of `priv_mode` or `virt_mode` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| priv_mode | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| virt_mode | input | 1 | Virtualization flag V |
| csr_req | input | 1 | CSR access strobe, one cycle per access |
| csr_we | input | 1 | 1 for write, 0 for read |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | DATA_W | Write data |
| csr_rdata | output | DATA_W | Read data, valid in the cycle of a legal read, else 0 |
| csr_illegal | output | 1 | Access raises an illegal-instruction condition |
| pte_xwr | input | 3 | Permission code of the leaf entry under check |
| pte_vs_stage | input | 1 | 1 when the entry belongs to the guest stage |
| pte_rsv | output | 1 | Permission code is reserved for that stage |
| xsse | output | 1 | Effective shadow-stack enable for the current mode |
| xlpe | output | 1 | Effective landing-pad enable for the current mode |

## Verification
The enable resolver is driven through every privilege and V combination, with the configuration bits set in patterns where the source levels differ. A wrong source level or a missing mask then shows up as a wrong `xsse` or `xlpe` value. Writes to the dependent shadow-stack fields are attempted both while their parent enable is clear and while it is set. The field is read back afterwards, which separates a dropped write from a masked read. A second instance built without a supervisor level checks that the user-mode source moves to the machine CSR and that the missing CSRs trap.

// File: rtl/cfi_gate_pkg.sv
package cfi_gate_pkg;

  typedef enum logic [1:0] {
    PRIV_U   = 2'd0,
    PRIV_S   = 2'd1,
    PRIV_RSV = 2'd2,
    PRIV_M   = 2'd3
  } priv_e;

  localparam logic [11:0] ADDR_MENV = 12'h30A;
  localparam logic [11:0] ADDR_SENV = 12'h10A;
  localparam logic [11:0] ADDR_HENV = 12'h60A;
  localparam logic [11:0] ADDR_MSEC = 12'h747;
  localparam logic [11:0] ADDR_SSP  = 12'h011;

  localparam int SSE_BIT = 3;
  localparam int LPE_BIT = 2;
  localparam int MLP_BIT = 10;

  typedef struct packed {
    logic m_sse;
    logic m_lpe;
    logic s_sse;
    logic s_lpe;
    logic h_sse;
    logic h_lpe;
    logic mlp;
  } cfg_t;

endpackage

// File: rtl/cfi_cfg_regs.sv
module cfi_cfg_regs
  import cfi_gate_pkg::*;
#(
  parameter bit HAS_SMODE = 1'b1,
  parameter bit HAS_HYP   = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [11:0] wr_addr,
  input  logic        wd_sse,
  input  logic        wd_lpe,
  input  logic        wd_mlp,
  input  logic        virt,
  output cfg_t        raw,
  output cfg_t        view
);

  localparam bit HAS_SREG = HAS_SMODE;
  localparam bit HAS_HREG = HAS_SMODE && HAS_HYP;

  cfg_t q;

  logic h_sse_open;
  logic s_sse_open;

  // A dependent field only accepts writes while its parent enable is set.
  assign h_sse_open = q.m_sse;
  assign s_sse_open = q.m_sse && (!virt || (q.h_sse && q.m_sse));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_MENV) begin
        q.m_sse <= wd_sse;
        q.m_lpe <= wd_lpe;
      end
      if (wr_addr == ADDR_MSEC) begin
        q.mlp <= wd_mlp;
      end
      if (HAS_SREG && wr_addr == ADDR_SENV) begin
        q.s_lpe <= wd_lpe;
        if (s_sse_open) q.s_sse <= wd_sse;
      end
      if (HAS_HREG && wr_addr == ADDR_HENV) begin
        q.h_lpe <= wd_lpe;
        if (h_sse_open) q.h_sse <= wd_sse;
      end
    end
  end

  assign raw = q;

  always_comb begin
    view       = q;
    view.h_sse = q.h_sse && q.m_sse;
    view.s_sse = q.s_sse && q.m_sse;
  end

endmodule

// File: rtl/cfi_mode_resolve.sv
module cfi_mode_resolve
  import cfi_gate_pkg::*;
#(
  parameter bit HAS_SMODE = 1'b1
) (
  input  cfg_t       view,
  input  logic [1:0] priv,
  input  logic       virt,
  output logic       xsse,
  output logic       xlpe
);

  generate
    if (HAS_SMODE) begin : g_msu
      always_comb begin
        xsse = 1'b0;
        xlpe = 1'b0;
        case (priv_e'(priv))
          PRIV_M: begin
            xsse = 1'b1;
            xlpe = view.mlp;
          end
          PRIV_S: begin
            if (virt) begin
              xsse = view.h_sse;
              xlpe = view.h_lpe;
            end else begin
              xsse = view.m_sse;
              xlpe = view.m_lpe;
            end
          end
          PRIV_U: begin
            xsse = view.s_sse && (!virt || view.h_sse);
            xlpe = view.s_lpe;
          end
          default: begin
            xsse = 1'b0;
            xlpe = 1'b0;
          end
        endcase
      end
    end else begin : g_mu
      logic unused_bits;
      assign unused_bits = virt ^ view.s_sse ^ view.s_lpe ^ view.h_sse ^ view.h_lpe;
      always_comb begin
        xsse = 1'b0;
        xlpe = 1'b0;
        case (priv_e'(priv))
          PRIV_M: begin
            xsse = 1'b1;
            xlpe = view.mlp;
          end
          PRIV_U: begin
            xsse = view.m_sse;
            xlpe = view.m_lpe;
          end
          default: begin
            xsse = 1'b0;
            xlpe = 1'b0;
          end
        endcase
      end
    end
  endgenerate

endmodule

// File: rtl/cfi_csr_read.sv
module cfi_csr_read
  import cfi_gate_pkg::*;
#(
  parameter bit HAS_SMODE = 1'b1,
  parameter bit HAS_HYP   = 1'b1,
  parameter int DATA_W    = 32
) (
  input  logic              req,
  input  logic              we,
  input  logic [11:0]       addr,
  input  cfg_t              view,
  input  logic              virt,
  input  logic [1:0]        priv,
  input  logic              xsse,
  output logic [DATA_W-1:0] rdata,
  output logic              illegal,
  output logic              wr_ok
);

  localparam bit HAS_SREG = HAS_SMODE;
  localparam bit HAS_HREG = HAS_SMODE && HAS_HYP;

  logic              known;
  logic              ssp_trap;
  logic [DATA_W-1:0] sel_data;
  logic              s_sse_rd;

  always_comb begin
    known = (addr == ADDR_MENV) || (addr == ADDR_MSEC) || (addr == ADDR_SSP);
    if (HAS_SREG && addr == ADDR_SENV) known = 1'b1;
    if (HAS_HREG && addr == ADDR_HENV) known = 1'b1;
  end

  assign ssp_trap = (addr == ADDR_SSP) && (priv_e'(priv) != PRIV_M) && !xsse;
  assign illegal  = req && (!known || ssp_trap);
  assign wr_ok    = req && we && !illegal;

  // Under V=1 the supervisor shadow-stack field also hides behind the hypervisor bit.
  assign s_sse_rd = view.s_sse && (!virt || view.h_sse);

  always_comb begin
    sel_data = '0;
    if (addr == ADDR_MENV) begin
      sel_data[SSE_BIT] = view.m_sse;
      sel_data[LPE_BIT] = view.m_lpe;
    end
    if (addr == ADDR_MSEC) begin
      sel_data[MLP_BIT] = view.mlp;
    end
    if (HAS_SREG && addr == ADDR_SENV) begin
      sel_data[SSE_BIT] = s_sse_rd;
      sel_data[LPE_BIT] = view.s_lpe;
    end
    if (HAS_HREG && addr == ADDR_HENV) begin
      sel_data[SSE_BIT] = view.h_sse;
      sel_data[LPE_BIT] = view.h_lpe;
    end
  end

  assign rdata = (req && !we && !illegal) ? sel_data : '0;

endmodule

// File: rtl/cfi_gate_unit.sv
module cfi_gate_unit
  import cfi_gate_pkg::*;
#(
  parameter bit HAS_SMODE = 1'b1,
  parameter bit HAS_HYP   = 1'b1,
  parameter int DATA_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        priv_mode,
  input  logic              virt_mode,
  input  logic              csr_req,
  input  logic              csr_we,
  input  logic [11:0]       csr_addr,
  input  logic [DATA_W-1:0] csr_wdata,
  output logic [DATA_W-1:0] csr_rdata,
  output logic              csr_illegal,
  input  logic [2:0]        pte_xwr,
  input  logic              pte_vs_stage,
  output logic              pte_rsv,
  output logic              xsse,
  output logic              xlpe
);

  localparam bit VIRT_OK = HAS_SMODE && HAS_HYP;

  cfg_t cfg_raw;
  cfg_t cfg_view;
  logic virt_eff;
  logic wr_ok;
  logic stage_sse;

  assign virt_eff = VIRT_OK && virt_mode;

  cfi_cfg_regs #(.HAS_SMODE(HAS_SMODE), .HAS_HYP(HAS_HYP)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_ok),
    .wr_addr (csr_addr),
    .wd_sse  (csr_wdata[SSE_BIT]),
    .wd_lpe  (csr_wdata[LPE_BIT]),
    .wd_mlp  (csr_wdata[MLP_BIT]),
    .virt    (virt_eff),
    .raw     (cfg_raw),
    .view    (cfg_view)
  );

  cfi_mode_resolve #(.HAS_SMODE(HAS_SMODE)) u_resolve (
    .view (cfg_view),
    .priv (priv_mode),
    .virt (virt_eff),
    .xsse (xsse),
    .xlpe (xlpe)
  );

  cfi_csr_read #(.HAS_SMODE(HAS_SMODE), .HAS_HYP(HAS_HYP), .DATA_W(DATA_W)) u_read (
    .req     (csr_req),
    .we      (csr_we),
    .addr    (csr_addr),
    .view    (cfg_view),
    .virt    (virt_eff),
    .priv    (priv_mode),
    .xsse    (xsse),
    .rdata   (csr_rdata),
    .illegal (csr_illegal),
    .wr_ok   (wr_ok)
  );

  assign stage_sse = pte_vs_stage ? cfg_view.h_sse : cfg_view.m_sse;
  assign pte_rsv   = (pte_xwr == 3'b010) && !stage_sse;

endmodule

// File: rtl/cfi_gate_sva.sv
module cfi_gate_sva
  import cfi_gate_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        priv_mode,
  input logic              virt_mode,
  input logic              csr_req,
  input logic              csr_we,
  input logic [11:0]       csr_addr,
  input logic [DATA_W-1:0] csr_wdata,
  input logic [DATA_W-1:0] csr_rdata,
  input logic              csr_illegal,
  input logic [2:0]        pte_xwr,
  input logic              pte_vs_stage,
  input logic              pte_rsv,
  input logic              xsse,
  input logic              m_sse,
  input logic              s_sse,
  input logic              h_sse
);

  AST_MACHINE_SSE_ON: assert property (@(posedge clk) disable iff (!rst_n)
    priv_mode == 2'd3 |-> xsse); // R3

  AST_SSP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    csr_req && csr_addr == ADDR_SSP && priv_mode != 2'd3 && !xsse |-> csr_illegal); // R9

  AST_SSP_M_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    csr_req && csr_addr == ADDR_SSP && priv_mode == 2'd3 |-> !csr_illegal); // R9

  AST_PTE_S_RSV: assert property (@(posedge clk) disable iff (!rst_n)
    pte_xwr == 3'b010 && !pte_vs_stage && !m_sse |-> pte_rsv); // R10

  AST_SUP_SSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    csr_req && csr_we && csr_addr == ADDR_SENV && !m_sse |=> s_sse == $past(s_sse)); // R7

  AST_HYP_SSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    csr_req && csr_we && csr_addr == ADDR_HENV && !m_sse |=> h_sse == $past(h_sse)); // R7

  AST_USER_SSE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    priv_mode == 2'd0 && !virt_mode && !m_sse |-> !xsse); // R7

  AST_MENV_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    csr_req && csr_we && !csr_illegal && csr_addr == ADDR_MENV
    |=> m_sse == $past(csr_wdata[SSE_BIT])); // R2

  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    csr_illegal |-> csr_rdata == '0); // R11

endmodule

bind cfi_gate_unit cfi_gate_sva #(.DATA_W(DATA_W)) u_sva (
  .clk          (clk),
  .rst_n        (rst_n),
  .priv_mode    (priv_mode),
  .virt_mode    (virt_mode),
  .csr_req      (csr_req),
  .csr_we       (csr_we),
  .csr_addr     (csr_addr),
  .csr_wdata    (csr_wdata),
  .csr_rdata    (csr_rdata),
  .csr_illegal  (csr_illegal),
  .pte_xwr      (pte_xwr),
  .pte_vs_stage (pte_vs_stage),
  .pte_rsv      (pte_rsv),
  .xsse         (xsse),
  .m_sse        (cfg_raw.m_sse),
  .s_sse        (cfg_raw.s_sse),
  .h_sse        (cfg_raw.h_sse)
);

// File: tb/cfi_gate_unit_tb.sv
module cfi_gate_unit_tb;

  localparam int DW = 32;
  localparam logic [11:0] A_M   = 12'h30A;
  localparam logic [11:0] A_S   = 12'h10A;
  localparam logic [11:0] A_H   = 12'h60A;
  localparam logic [11:0] A_SEC = 12'h747;
  localparam logic [11:0] A_SSP = 12'h011;
  localparam logic [1:0]  PM = 2'd3, PS = 2'd1, PU = 2'd0;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  int            sel = 0;
  logic          req = 1'b0, we = 1'b0, virt = 1'b0, vs = 1'b0;
  logic [1:0]    priv = 2'd3;
  logic [11:0]   addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [2:0]    xwr = '0;

  logic [DW-1:0] rd_a, rd_b;
  logic          ill_a, ill_b, pte_a, pte_b, sse_a, sse_b, lpe_a, lpe_b;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  done     = 1'b0;

  typedef struct {
    int            sel;
    logic [DW-1:0] rd;
    logic          ill;
    logic          sse;
    logic          lpe;
    logic          pte;
    string         tag;
  } exp_t;

  exp_t q[$];

  always #10 clk = ~clk;

  cfi_gate_unit #(.HAS_SMODE(1'b1), .HAS_HYP(1'b1), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .priv_mode(priv), .virt_mode(virt),
    .csr_req(req && sel == 0), .csr_we(we), .csr_addr(addr), .csr_wdata(wdata),
    .csr_rdata(rd_a), .csr_illegal(ill_a), .pte_xwr(xwr), .pte_vs_stage(vs),
    .pte_rsv(pte_a), .xsse(sse_a), .xlpe(lpe_a)
  );

  cfi_gate_unit #(.HAS_SMODE(1'b0), .HAS_HYP(1'b0), .DATA_W(DW)) u_dut_mu (
    .clk(clk), .rst_n(rst_n), .priv_mode(priv), .virt_mode(virt),
    .csr_req(req && sel == 1), .csr_we(we), .csr_addr(addr), .csr_wdata(wdata),
    .csr_rdata(rd_b), .csr_illegal(ill_b), .pte_xwr(xwr), .pte_vs_stage(vs),
    .pte_rsv(pte_b), .xsse(sse_b), .xlpe(lpe_b)
  );

  // Monitor: compares the oldest expected item half a phase after it is driven.
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (q.size() > 0) begin
        exp_t e;
        logic [DW-1:0] a_rd;
        logic a_ill, a_sse, a_lpe, a_pte;
        e = q.pop_front();
        a_rd  = (e.sel == 0) ? rd_a  : rd_b;
        a_ill = (e.sel == 0) ? ill_a : ill_b;
        a_sse = (e.sel == 0) ? sse_a : sse_b;
        a_lpe = (e.sel == 0) ? lpe_a : lpe_b;
        a_pte = (e.sel == 0) ? pte_a : pte_b;
        n_checks++;
        if (a_rd !== e.rd || a_ill !== e.ill || a_sse !== e.sse ||
            a_lpe !== e.lpe || a_pte !== e.pte) begin
          n_fail++;
          $display("FAIL %s: actual rd=%h ill=%b sse=%b lpe=%b pte=%b expected rd=%h ill=%b sse=%b lpe=%b pte=%b",
                   e.tag, a_rd, a_ill, a_sse, a_lpe, a_pte, e.rd, e.ill, e.sse, e.lpe, e.pte);
        end
      end
    end
  end

  task automatic drive(int s, logic r, logic w, logic [11:0] a, logic [DW-1:0] d,
                       logic [1:0] p, logic v, logic [2:0] x, logic st);
    @(negedge clk);
    sel = s; req = r; we = w; addr = a; wdata = d;
    priv = p; virt = v; xwr = x; vs = st;
  endtask

  task automatic push(int s, logic [DW-1:0] erd, logic eill, logic esse,
                      logic elpe, logic epte, string tag);
    exp_t e;
    e.sel = s; e.rd = erd; e.ill = eill; e.sse = esse; e.lpe = elpe; e.pte = epte; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic wr(int s, logic [11:0] a, logic [DW-1:0] d, logic [1:0] p, logic v);
    drive(s, 1'b1, 1'b1, a, d, p, v, 3'b000, 1'b0);
  endtask

  task automatic rd(int s, logic [11:0] a, logic [1:0] p, logic v, logic [DW-1:0] erd,
                    logic eill, logic esse, logic elpe, string tag);
    drive(s, 1'b1, 1'b0, a, '0, p, v, 3'b000, 1'b0);
    push(s, erd, eill, esse, elpe, 1'b0, tag);
  endtask

  task automatic look(int s, logic [1:0] p, logic v, logic esse, logic elpe, string tag);
    drive(s, 1'b0, 1'b0, '0, '0, p, v, 3'b000, 1'b0);
    push(s, '0, 1'b0, esse, elpe, 1'b0, tag);
  endtask

  task automatic pt(int s, logic [1:0] p, logic v, logic st, logic epte,
                    logic esse, logic elpe, string tag);
    drive(s, 1'b0, 1'b0, '0, '0, p, v, 3'b010, st);
    push(s, '0, 1'b0, esse, elpe, epte, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // Main instance: supervisor and hypervisor present
    look(0, PM, 0, 1, 0, "R1 R3 reset idle in M");
    rd(0, A_M,   PM, 0, 32'h0, 0, 1, 0, "R1 machine cfg after reset");
    rd(0, A_S,   PM, 0, 32'h0, 0, 1, 0, "R1 supervisor cfg after reset");
    rd(0, A_H,   PM, 0, 32'h0, 0, 1, 0, "R1 hypervisor cfg after reset");
    rd(0, A_SEC, PM, 0, 32'h0, 0, 1, 0, "R1 security cfg after reset");
    pt(0, PU, 0, 0, 1, 0, 0, "R10 single stage reserved while machine SSE off");
    wr(0, A_S, 32'hC, PM, 0);
    rd(0, A_S, PM, 0, 32'h4, 0, 1, 0, "R7 supervisor SSE write dropped");
    look(0, PU, 0, 0, 1, "R5 U takes supervisor LPE");
    rd(0, A_SSP, PU, 0, 32'h0, 1, 0, 1, "R9 ssp from U traps while xsse 0");
    rd(0, A_SSP, PM, 0, 32'h0, 0, 1, 0, "R9 ssp from M legal");
    wr(0, A_M, 32'hFFFF_FFFF, PM, 0);
    rd(0, A_M, PM, 0, 32'hC, 0, 1, 0, "R2 machine cfg field bits");
    rd(0, A_S, PM, 0, 32'h4, 0, 1, 0, "R7 earlier dropped write stays dropped");
    look(0, PS, 0, 1, 1, "R4 S takes machine fields");
    look(0, PU, 0, 0, 1, "R5 U with supervisor SSE 0");
    wr(0, A_S, 32'h8, PM, 0);
    rd(0, A_S, PM, 0, 32'h8, 0, 1, 0, "R2 supervisor cfg write visible");
    look(0, PU, 0, 1, 0, "R5 U takes supervisor SSE");
    rd(0, A_SSP, PU, 0, 32'h0, 0, 1, 0, "R9 ssp from U legal while xsse 1");
    pt(0, PU, 0, 0, 0, 1, 0, "R10 single stage legal while machine SSE on");
    look(0, PU, 1, 0, 0, "R5 R8 VU needs hypervisor SSE");
    rd(0, A_S, PS, 1, 32'h0, 0, 0, 0, "R8 supervisor SSE hidden under V");
    wr(0, A_S, 32'h4, PS, 1);
    rd(0, A_S, PM, 0, 32'hC, 0, 1, 0, "R8 SSE write under V dropped, LPE taken");
    pt(0, PS, 1, 1, 1, 0, 0, "R10 guest stage reserved while hypervisor SSE off");
    wr(0, A_H, 32'hC, PM, 0);
    rd(0, A_H, PM, 0, 32'hC, 0, 1, 0, "R2 hypervisor cfg write visible");
    look(0, PS, 1, 1, 1, "R4 VS takes hypervisor fields");
    look(0, PU, 1, 1, 1, "R5 VU with all levels on");
    pt(0, PS, 1, 1, 0, 1, 1, "R10 guest stage legal while hypervisor SSE on");
    wr(0, A_SEC, 32'hFFFF_FFFF, PM, 0);
    rd(0, A_SEC, PM, 0, 32'h400, 0, 1, 1, "R2 R3 machine landing-pad bit");
    wr(0, A_SEC, 32'h0, PM, 0);
    look(0, PM, 0, 1, 0, "R12 M lpe 0");
    look(0, PU, 0, 1, 1, "R12 switch to U same cycle");
    look(0, PM, 0, 1, 0, "R12 back to M same cycle");
    rd(0, 12'h123, PM, 0, 32'h0, 1, 1, 0, "R11 unknown address read");
    drive(0, 1'b1, 1'b1, 12'h123, 32'hFFFF_FFFF, PM, 1'b0, 3'b000, 1'b0);
    push(0, 32'h0, 1'b1, 1'b1, 1'b0, 1'b0, "R11 unknown address write");
    rd(0, A_M, PM, 0, 32'hC, 0, 1, 0, "R11 unknown write changed nothing");
    wr(0, A_M, 32'h0, PM, 0);
    rd(0, A_H, PM, 0, 32'h4, 0, 1, 0, "R7 hypervisor SSE masked");
    rd(0, A_S, PM, 0, 32'h4, 0, 1, 0, "R7 supervisor SSE masked");
    look(0, PU, 0, 0, 1, "R7 U shadow stack off");
    look(0, PS, 0, 0, 0, "R4 S after machine cleared");

    // Second instance: machine and user only
    rd(1, A_S, PM, 0, 32'h0, 1, 1, 0, "R11 no supervisor CSR");
    rd(1, A_H, PM, 0, 32'h0, 1, 1, 0, "R11 no hypervisor CSR");
    look(1, PU, 0, 0, 0, "R6 U after reset");
    rd(1, A_SSP, PU, 0, 32'h0, 1, 0, 0, "R9 MU ssp from U traps");
    wr(1, A_M, 32'h8, PM, 0);
    look(1, PU, 0, 1, 0, "R6 U takes machine SSE");
    rd(1, A_SSP, PU, 0, 32'h0, 0, 1, 0, "R9 MU ssp from U legal");
    wr(1, A_M, 32'h4, PM, 0);
    look(1, PU, 0, 0, 1, "R6 U takes machine LPE");
    pt(1, PU, 0, 0, 1, 0, 1, "R10 MU reserved encoding");
    look(1, PS, 0, 0, 0, "R6 absent S mode");
    rd(1, A_M, PM, 0, 32'h4, 0, 1, 0, "R2 MU machine cfg");

    drive(0, 1'b0, 1'b0, '0, '0, PM, 1'b0, 3'b000, 1'b0);
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule